// File: doc/BRIEF.md
# PHY Control Register Bank with Bit-Enable Writes

This block holds the static control state of a camera-side PHY receiver and its companion link in a small set of 16-bit registers reached over a plain 32-bit register bus. Each write word is split in two. The low half carries the new bit values. The high half carries one enable bit per register bit. Only bits whose enable is set take the new value, so driver code can change one field, such as a single lane-enable nibble or the test clock bit, in one bus write. It does not have to read the register first.

The registers fan out as named field ports: lane enables, forced receive and forced stop nibbles, turnaround disable and request nibbles, two clock-invert selects, the link's source, direction, clock-enable and master selects, and the PHY test port (an input byte, an enable, a clock and a clear). A read-only status address returns the byte the PHY presents on its test output. Reads and writes have separate strobes and addresses, so both may occur in the same cycle. Read data is registered and appears one cycle after the read strobe.

Top module: `phy_ctl_regbank`

## Requirements
- R1: After reset every control register reads as zero and every field output is zero.
- R2: On a write to a decoded control address, register bit k (k in 0..15) takes write-data bit k only when write-data bit 16+k is 1; all other bits keep their value.
- R3: A write whose upper 16 data bits are all zero leaves the addressed register unchanged, whatever its lower 16 bits hold.
- R4: Only implemented bits store data: mask 0x0C0F at address 0x6224, 0xFFFF at 0x6254, 0x00FF at 0x6260 and 0x07FF at 0x6264. All other bits always read as zero.
- R5: A write to any address other than the four control addresses changes no register, and a read from any address other than those four and the status address returns zero.
- R6: A read strobe with a control address returns that register in read-data bits [15:0] on the cycle after the strobe, with bits [31:16] zero.
- R7: A read of status address 0xE2A4 returns the test output byte, as sampled at the read edge, in bits [7:0] with all other bits zero. Writes to that address have no effect.
- R8: Field mapping. At 0x6224, [3:0] is link turn-request, bit 10 is receiver-0 clock invert and bit 11 is receiver-1 clock invert. At 0x6254, [3:0] is lane enable, [7:4] force-receive, [11:8] force-stop and [15:12] turn-disable. At 0x6260, [3:0] is link-1 turn-request, bit 4 is source select, bit 5 base direction, bit 6 clock enable and bit 7 master select. At 0x6264, [7:0] is test input byte, bit 8 test enable, bit 9 test clock and bit 10 test clear.
- R9: When a read and a write address the same register in one cycle, the read returns the value from before the write, and the following read returns the written value.
- R10: A write reaches the field outputs on the clock edge at which it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 32 | [31:16] bit enables, [15:0] values |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read byte address |
| rd_data | output | 32 | Registered read data |
| tst_dout | input | 8 | Test output byte from the PHY |
| lnk_turn_req | output | 4 | Link turnaround request per lane |
| rx0_clk_inv | output | 1 | Receiver 0 clock invert |
| rx1_clk_inv | output | 1 | Receiver 1 clock invert |
| rx0_lane_en | output | 4 | Receiver 0 lane enables |
| rx0_force_rx | output | 4 | Receiver 0 forced receive mode |
| rx0_force_stop | output | 4 | Receiver 0 forced stop state |
| rx0_turn_dis | output | 4 | Receiver 0 turnaround disable |
| lnk1_turn_req | output | 4 | Link 1 turnaround request |
| lnk1_src_sel | output | 1 | Link 1 source select |
| lnk1_base_dir | output | 1 | Link 1 base direction |
| lnk1_clk_en | output | 1 | Link 1 clock lane enable |
| lnk1_master | output | 1 | Link 1 master select |
| tst_din | output | 8 | Test port input byte |
| tst_en | output | 1 | Test port enable |
| tst_clk | output | 1 | Test port clock |
| tst_clr | output | 1 | Test port clear |

## Verification
The collision of interest is a read and a masked write that address the same register in the same cycle. The stimulus produces it with directed steps and with random steps that draw both addresses from a small pool, so they often match. The bench model computes the read result from its copy of the register taken before it applies the merge, and the field outputs from the copy taken after. A design that forwards write data into the read path, or that delays the update, disagrees with the model on one of the two. Status reads are paired with randomly changing test output bytes in the same way, which shows that the byte is sampled at the read edge.

// File: rtl/phy_ctl_regbank_pkg.sv
package phy_ctl_regbank_pkg;

    localparam int NREG   = 4;
    localparam int REG_W  = 16;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 16;
    localparam int STAT_W = 8;

    // register slots; the slot order is the order of the packed lists below
    localparam int SLOT_LINK  = 0;
    localparam int SLOT_RX0   = 1;
    localparam int SLOT_LINK1 = 2;
    localparam int SLOT_TEST  = 3;

    localparam logic [NREG*ADDR_W-1:0] SLOT_ADDRS =
        {16'h6264, 16'h6260, 16'h6254, 16'h6224};
    localparam logic [NREG*REG_W-1:0] SLOT_MASKS =
        {16'h07FF, 16'h00FF, 16'hFFFF, 16'h0C0F};
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 16'hE2A4;

    typedef struct packed {
        logic [NREG-1:0][REG_W-1:0] regs;
        logic [BUS_W-1:0]           rdata;
    } bank_t;

endpackage

// File: rtl/phy_ctl_addr_dec.sv
module phy_ctl_addr_dec #(
    parameter int NREG   = 4,
    parameter int ADDR_W = 16,
    parameter logic [NREG*ADDR_W-1:0] ADDR_LIST = '0
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel
);

    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        assign sel[i] = en && (addr == ADDR_LIST[i*ADDR_W +: ADDR_W]);
    end

    always_comb begin
        if (!$isunknown(sel)) begin
            AST_SEL_ONEHOT: assert ($onehot0(sel)); // R5
        end
    end

endmodule

// File: rtl/phy_ctl_mask_merge.sv
module phy_ctl_mask_merge #(
    parameter int REG_W = 16,
    parameter logic [REG_W-1:0] IMPL_MASK = '1
) (
    input  logic             hit,
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] wval,
    input  logic [REG_W-1:0] wbe,
    output logic [REG_W-1:0] nxt
);

    logic [REG_W-1:0] merged;

    always_comb begin
        merged = (cur & ~wbe) | (wval & wbe);
        nxt    = hit ? (merged & IMPL_MASK) : cur;
    end

endmodule

// File: rtl/phy_ctl_rd_mux.sv
module phy_ctl_rd_mux #(
    parameter int NREG   = 4,
    parameter int REG_W  = 16,
    parameter int BUS_W  = 32,
    parameter int STAT_W = 8
) (
    input  logic [NREG-1:0]             sel,
    input  logic                        stat_hit,
    input  logic [NREG-1:0][REG_W-1:0]  regs,
    input  logic [STAT_W-1:0]           stat,
    output logic [BUS_W-1:0]            word
);

    localparam int PAD_REG  = BUS_W - REG_W;
    localparam int PAD_STAT = BUS_W - STAT_W;

    always_comb begin
        word = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) begin
                word = word | {{PAD_REG{1'b0}}, regs[i]};
            end
        end
        if (stat_hit) begin
            word = word | {{PAD_STAT{1'b0}}, stat};
        end
    end

endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
    import phy_ctl_regbank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BUS_W,
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic [SW-1:0] tst_dout,
    output logic [3:0]    lnk_turn_req,
    output logic          rx0_clk_inv,
    output logic          rx1_clk_inv,
    output logic [3:0]    rx0_lane_en,
    output logic [3:0]    rx0_force_rx,
    output logic [3:0]    rx0_force_stop,
    output logic [3:0]    rx0_turn_dis,
    output logic [3:0]    lnk1_turn_req,
    output logic          lnk1_src_sel,
    output logic          lnk1_base_dir,
    output logic          lnk1_clk_en,
    output logic          lnk1_master,
    output logic [7:0]    tst_din,
    output logic          tst_en,
    output logic          tst_clk,
    output logic          tst_clr
);

    localparam int PAD_STAT = DW - SW;

    bank_t st_d, st_q;

    logic [NREG-1:0]            wr_sel, rd_sel;
    logic                       rd_stat;
    logic [NREG-1:0][REG_W-1:0] nxt_regs;
    logic [DW-1:0]              rd_word;
    logic [REG_W-1:0]           wr_val, wr_be;

    assign wr_val  = wr_data[REG_W-1:0];
    assign wr_be   = wr_data[2*REG_W-1:REG_W];
    assign rd_stat = rd_en && (rd_addr == STATUS_ADDR);

    phy_ctl_addr_dec #(
        .NREG(NREG), .ADDR_W(AW), .ADDR_LIST(SLOT_ADDRS)
    ) u_wr_dec (
        .en(wr_en), .addr(wr_addr), .sel(wr_sel)
    );

    phy_ctl_addr_dec #(
        .NREG(NREG), .ADDR_W(AW), .ADDR_LIST(SLOT_ADDRS)
    ) u_rd_dec (
        .en(rd_en), .addr(rd_addr), .sel(rd_sel)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        phy_ctl_mask_merge #(
            .REG_W(REG_W), .IMPL_MASK(SLOT_MASKS[i*REG_W +: REG_W])
        ) u_merge (
            .hit(wr_sel[i]), .cur(st_q.regs[i]), .wval(wr_val),
            .wbe(wr_be), .nxt(nxt_regs[i])
        );

        AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.regs[i] & ~SLOT_MASKS[i*REG_W +: REG_W]) == '0); // R4

        AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_sel[i] |=>
            ((st_q.regs[i] ^ $past(st_q.regs[i])) & ~$past(wr_data[2*REG_W-1:REG_W])) == '0); // R2
    end

    phy_ctl_rd_mux #(
        .NREG(NREG), .REG_W(REG_W), .BUS_W(DW), .STAT_W(SW)
    ) u_rd_mux (
        .sel(rd_sel), .stat_hit(rd_stat), .regs(st_q.regs),
        .stat(tst_dout), .word(rd_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.regs = nxt_regs;
        if (rd_en) begin
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data        = st_q.rdata;
    assign lnk_turn_req   = st_q.regs[SLOT_LINK][3:0];
    assign rx0_clk_inv    = st_q.regs[SLOT_LINK][10];
    assign rx1_clk_inv    = st_q.regs[SLOT_LINK][11];
    assign rx0_lane_en    = st_q.regs[SLOT_RX0][3:0];
    assign rx0_force_rx   = st_q.regs[SLOT_RX0][7:4];
    assign rx0_force_stop = st_q.regs[SLOT_RX0][11:8];
    assign rx0_turn_dis   = st_q.regs[SLOT_RX0][15:12];
    assign lnk1_turn_req  = st_q.regs[SLOT_LINK1][3:0];
    assign lnk1_src_sel   = st_q.regs[SLOT_LINK1][4];
    assign lnk1_base_dir  = st_q.regs[SLOT_LINK1][5];
    assign lnk1_clk_en    = st_q.regs[SLOT_LINK1][6];
    assign lnk1_master    = st_q.regs[SLOT_LINK1][7];
    assign tst_din        = st_q.regs[SLOT_TEST][7:0];
    assign tst_en         = st_q.regs[SLOT_TEST][8];
    assign tst_clk        = st_q.regs[SLOT_TEST][9];
    assign tst_clr        = st_q.regs[SLOT_TEST][10];

    AST_NO_EN_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_data[2*REG_W-1:REG_W] == '0) |=> $stable(st_q.regs)); // R3

    AST_UNDECODED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_sel == '0) |=> $stable(st_q.regs)); // R5

    AST_UNDECODED_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (rd_sel == '0) && !rd_stat |=> rd_data == '0); // R5

    AST_STATUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (rd_data[SW-1:0] == $past(tst_dout))
                    && (rd_data[DW-1:SW] == {PAD_STAT{1'b0}})); // R7

endmodule

// File: tb/phy_ctl_regbank_test.sv
`timescale 1ns/1ps
module phy_ctl_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  tst_dout = '0;
    logic [3:0]  lnk_turn_req, rx0_lane_en, rx0_force_rx, rx0_force_stop;
    logic [3:0]  rx0_turn_dis, lnk1_turn_req;
    logic        rx0_clk_inv, rx1_clk_inv, lnk1_src_sel, lnk1_base_dir;
    logic        lnk1_clk_en, lnk1_master, tst_en, tst_clk, tst_clr;
    logic [7:0]  tst_din;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [15:0] A_LINK = 16'h6224, A_RX0 = 16'h6254,
                            A_LNK1 = 16'h6260, A_TEST = 16'h6264,
                            A_STAT = 16'hE2A4, A_HOLE = 16'h6258;
    logic [15:0] ba [4] = '{A_LINK, A_RX0, A_LNK1, A_TEST};
    logic [15:0] bm [4] = '{16'h0C0F, 16'hFFFF, 16'h00FF, 16'h07FF};
    logic [15:0] mdl [4] = '{16'h0, 16'h0, 16'h0, 16'h0};

    always #2.5 clk = ~clk;

    phy_ctl_regbank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .tst_dout(tst_dout), .lnk_turn_req(lnk_turn_req),
        .rx0_clk_inv(rx0_clk_inv), .rx1_clk_inv(rx1_clk_inv),
        .rx0_lane_en(rx0_lane_en), .rx0_force_rx(rx0_force_rx),
        .rx0_force_stop(rx0_force_stop), .rx0_turn_dis(rx0_turn_dis),
        .lnk1_turn_req(lnk1_turn_req), .lnk1_src_sel(lnk1_src_sel),
        .lnk1_base_dir(lnk1_base_dir), .lnk1_clk_en(lnk1_clk_en),
        .lnk1_master(lnk1_master), .tst_din(tst_din), .tst_en(tst_en),
        .tst_clk(tst_clk), .tst_clr(tst_clr)
    );

    function automatic logic [31:0] exp_read(input logic [15:0] a, input logic [7:0] d);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) if (a == ba[i]) r = {16'h0, mdl[i]};
        if (a == A_STAT) r = {24'h0, d};
        return r;
    endfunction

    function automatic logic [40:0] exp_fields();
        return {mdl[0][3:0], mdl[0][10], mdl[0][11], mdl[1], mdl[2][7:0], mdl[3][10:0]};
    endfunction

    function automatic logic [40:0] act_fields();
        return {lnk_turn_req, rx0_clk_inv, rx1_clk_inv, rx0_turn_dis, rx0_force_stop,
                rx0_force_rx, rx0_lane_en, lnk1_master, lnk1_clk_en, lnk1_base_dir,
                lnk1_src_sel, lnk1_turn_req, tst_clr, tst_clk, tst_en, tst_din};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus step: drive at negedge, model update, sample at next negedge
    task automatic step(input bit we, input logic [15:0] wa, input logic [31:0] wd,
                        input bit re, input logic [15:0] ra, input logic [7:0] dout,
                        input string rreq, input string freq);
        logic [31:0] er;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra; tst_dout = dout;
        er = exp_read(ra, dout);
        if (we) begin
            for (int i = 0; i < 4; i++)
                if (wa == ba[i])
                    mdl[i] = ((mdl[i] & ~wd[31:16]) | (wd[15:0] & wd[31:16])) & bm[i];
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (re) check(rreq, {32'h0, rd_data}, {32'h0, er});
        check(freq, {23'h0, act_fields()}, {23'h0, exp_fields()});
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        step(1'b0, 16'h0, 32'h0, 1'b1, a, tst_dout, req, "R8");
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input string req);
        step(1'b1, a, d, 1'b0, 16'h0, tst_dout, req, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] pool [6];
        pool = '{A_LINK, A_RX0, A_LNK1, A_TEST, A_STAT, A_HOLE};
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state at the ports and on readback
        check("R1", {23'h0, act_fields()}, 64'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) rd(ba[i], "R1");

        // R4: all-ones write keeps only implemented bits
        for (int i = 0; i < 4; i++) wr(ba[i], 32'hFFFF_FFFF, "R4");
        for (int i = 0; i < 4; i++) rd(ba[i], "R4");
        for (int i = 0; i < 4; i++) wr(ba[i], 32'hFFFF_0000, "R2");

        // R2: single-field update on the receiver register
        wr(A_RX0, 32'h00F0_ABCD, "R2");
        rd(A_RX0, "R2");
        wr(A_RX0, 32'h0F00_5A5A, "R2");
        rd(A_RX0, "R6");

        // R3: enable half zero
        wr(A_RX0, 32'h0000_FFFF, "R3");
        rd(A_RX0, "R3");

        // R5: undecoded write and read
        wr(A_HOLE, 32'hFFFF_FFFF, "R5");
        for (int i = 0; i < 4; i++) rd(ba[i], "R5");
        rd(A_HOLE, "R5");

        // R7: status read and write to status address
        step(1'b0, 16'h0, 32'h0, 1'b1, A_STAT, 8'hA5, "R7", "R8");
        wr(A_STAT, 32'hFFFF_FFFF, "R7");
        rd(A_TEST, "R7");

        // R10 and R8: test port bits toggled one at a time
        wr(A_TEST, 32'h0200_0200, "R10");
        wr(A_TEST, 32'h0100_0100, "R10");
        wr(A_TEST, 32'h00FF_003C, "R8");

        // R9: read and write to the same register in one cycle
        step(1'b1, A_LNK1, 32'h00FF_00A6, 1'b1, A_LNK1, 8'h00, "R9", "R10");
        rd(A_LNK1, "R9");

        // random mix, addresses drawn from a small pool so collisions are frequent
        for (int k = 0; k < 400; k++) begin
            logic [31:0] d;
            logic [15:0] wa, ra;
            int mode;
            mode = $urandom_range(0, 5);
            d  = $urandom();
            if (mode == 0) d[31:16] = 16'h0;
            wa = pool[$urandom_range(0, 5)];
            ra = (mode == 1) ? wa : pool[$urandom_range(0, 5)];
            step($urandom_range(0, 3) != 0, wa, d, $urandom_range(0, 1) == 1, ra,
                 8'($urandom()), "R9", "R2");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule